// File: doc/BRIEF.md
# Strap-Sampled Platform Configuration Register

This block is a 32-bit configuration and status word inside a platform I/O controller. It sits at a single word address on a simple read/write port. Its fields live in three reset domains, each cleared by its own synchronous reset input:

- The RTC domain holds the boot-block swap bit and the processor frequency multiplier field.
- The resume domain holds the processor self-test enable bit.
- The core domain holds the watchdog no-reboot flag.

When the power-good input rises, the block samples two strap pins. One strap sets a safe-mode flag, which forces the multiplier to all ones. The other strap, when it is held low by a jumper, sets the no-reboot flag. The same jumper also keeps software from clearing that flag.

The block drives four kinds of output:

- A firmware address-bit output. Its upper bit is inverted for boot-space cycles while the swap bit is set.
- A processor init output. It follows the processor reset while self-test is enabled.
- The effective multiplier.
- The two status flags.

All outputs are registered. The power-good input and both straps pass through synchronizer stages before they are used.

Top module: `strap_cfg_reg`

## Requirements
- R1: After all three resets, with power-good having risen while the safe strap was low and the speaker strap was high, a read of the register returns 0x00000F00.
- R2: Bits 31:14, 7:3 and 0 always read as zero. Bit 2 is read-only. Writing ones to any of these bits changes nothing in the read value.
- R3: Bit 13 is the swap bit. `fw_a16_o` equals `fw_a16_i` XOR (swap bit AND `fw_boot_sel_i`), one clock after its inputs change. When `fw_boot_sel_i` is 0 (feature space), the address bit is never inverted.
- R4: Bit 13 and the stored multiplier in bits 11:8 are cleared (to 0 and to 1111) only by `rst_rtc_i`. The resume and core resets leave them unchanged.
- R5: Bit 12 is the self-test enable and is cleared by `rst_rsm_i`. `init_o` is `cpu_rst_i` delayed by one clock while bit 12 is set, and it is 0 while bit 12 is clear.
- R6: Bits 11:8 can be written only while bit 2 is 0. While bit 2 is 1, both the read value of bits 11:8 and `freq_mult_o` are 1111. Once bit 2 returns to 0, the previously stored multiplier reappears.
- R7: On each rising edge of the synchronized power-good signal, bit 2 captures the level of `strap_safe_i`. Between such edges, and regardless of writes, bit 2 does not change.
- R8: Bit 1 is set when the power-good edge sees `strap_spkr_n_i` low, and it is set when software writes 1 to it. A written 0 clears it only while `strap_spkr_n_i` is high. `rst_core_i` clears it.
- R9: A write updates only the bytes whose byte enable is set, where `be_i[0]` covers bits 7:0 and `be_i[1]` covers bits 15:8. Accesses to any word address other than 0xD4 to 0xD7 (so `addr_i[7:2]` differs) are ignored, and reads of them return 0.
- R10: `rdata_o` is loaded on the clock edge on which `rd_en_i` is high and holds its value while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_rtc_i | input | 1 | RTC-domain synchronous reset, active high |
| rst_rsm_i | input | 1 | Resume-domain synchronous reset, active high |
| rst_core_i | input | 1 | Core-domain synchronous reset, active high |
| pwr_good_i | input | 1 | Power-good level; its rising edge samples the straps |
| strap_safe_i | input | 1 | Safe-mode strap pin |
| strap_spkr_n_i | input | 1 | Speaker strap pin; low means the no-reboot jumper is fitted |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte address |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| cpu_rst_i | input | 1 | Processor reset active |
| fw_a16_i | input | 1 | Firmware address bit 16 from the cycle |
| fw_boot_sel_i | input | 1 | 1 for a boot-space cycle, 0 for a feature-space cycle |
| fw_a16_o | output | 1 | Address bit 16 after the swap |
| init_o | output | 1 | Processor init request |
| top_swap_o | output | 1 | Swap bit |
| freq_mult_o | output | 4 | Effective frequency multiplier |
| safe_mode_o | output | 1 | Safe-mode flag |
| no_reboot_o | output | 1 | Watchdog no-reboot flag |

## Verification
A wrong stored bit shows on the read port on the cycle after the next read. The swap bit, self-test bit and effective multiplier also show, one clock later, on `fw_a16_o`, `init_o` and `freq_mult_o`. If a reset domain clears the wrong field, the next read after that reset gives a value that differs from the expected constant. If a strap is sampled wrongly, the read returns the wrong bits 2:1 a few clocks after power-good rises: two synchronizer stages, one edge detector, then the capture register. A safe-mode flag that is lost or stuck shows up in the multiplier nibble, which either reads all ones or shows the stored value.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned FREQ_W    = 4;
  localparam int unsigned BIT_SWAP  = 13;
  localparam int unsigned BIT_BIST  = 12;
  localparam int unsigned FREQ_LSB  = 8;
  localparam int unsigned BIT_SAFE  = 2;
  localparam int unsigned BIT_NORB  = 1;
  localparam logic [FREQ_W-1:0] FREQ_SAFE = '1;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/strap_cfg_fields.sv
module strap_cfg_fields
  import strap_cfg_pkg::*;
#(
  parameter int unsigned FW = FREQ_W
) (
  input  logic          clk,
  input  logic          rst_rtc_i,
  input  logic          rst_rsm_i,
  input  logic          rst_core_i,
  input  logic          pg_rise_i,
  input  logic          safe_s_i,
  input  logic          spkr_n_s_i,
  input  logic          wr_hit_i,
  input  logic [1:0]    be_lo_i,
  input  logic [15:0]   wdata_lo_i,
  output logic          swap_q,
  output logic          bist_q,
  output logic [FW-1:0] freq_q,
  output logic          safe_q,
  output logic          norb_q
);
  logic wr_b0, wr_b1;
  assign wr_b0 = wr_hit_i && be_lo_i[0];
  assign wr_b1 = wr_hit_i && be_lo_i[1];

  // RTC domain: swap, stored multiplier, safe flag
  always_ff @(posedge clk) begin
    if (rst_rtc_i) begin
      swap_q <= 1'b0;
      freq_q <= '1;
      safe_q <= 1'b0;
    end else begin
      if (wr_b1) swap_q <= wdata_lo_i[BIT_SWAP];
      if (wr_b1 && !safe_q) freq_q <= wdata_lo_i[FREQ_LSB +: FW];
      if (pg_rise_i) safe_q <= safe_s_i;
    end
  end

  // Resume domain: self-test enable
  always_ff @(posedge clk) begin
    if (rst_rsm_i) bist_q <= 1'b0;
    else if (wr_b1) bist_q <= wdata_lo_i[BIT_BIST];
  end

  // Core domain: no-reboot, strap-set and write-one-to-set, clear blocked by jumper
  always_ff @(posedge clk) begin
    if (rst_core_i) norb_q <= 1'b0;
    else if (pg_rise_i && !spkr_n_s_i) norb_q <= 1'b1;
    else if (wr_b0) begin
      if (wdata_lo_i[BIT_NORB]) norb_q <= 1'b1;
      else if (spkr_n_s_i) norb_q <= 1'b0;
    end
  end

  AST_SAFE_HOLD: assert property (@(posedge clk) disable iff (rst_rtc_i)
    !pg_rise_i |=> $stable(safe_q)); // R7
  AST_NORB_NO_CLEAR: assert property (@(posedge clk) disable iff (rst_rtc_i || rst_core_i)
    (norb_q && !spkr_n_s_i) |=> norb_q); // R8
  AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (rst_rtc_i)
    !wr_b1 |=> $stable(swap_q)); // R4
endmodule

// File: rtl/strap_cfg_reg.sv
module strap_cfg_reg
  import strap_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [7:0]  REG_ADDR    = 8'hD4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_rtc_i,
  input  logic              rst_rsm_i,
  input  logic              rst_core_i,
  input  logic              pwr_good_i,
  input  logic              strap_safe_i,
  input  logic              strap_spkr_n_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              cpu_rst_i,
  input  logic              fw_a16_i,
  input  logic              fw_boot_sel_i,
  output logic              fw_a16_o,
  output logic              init_o,
  output logic              top_swap_o,
  output logic [FREQ_W-1:0] freq_mult_o,
  output logic              safe_mode_o,
  output logic              no_reboot_o
);
  logic [2:0] sync_q;
  logic       pg_s, pg_d, pg_rise;
  logic       hit;
  logic       swap_q, bist_q, safe_q, norb_q;
  logic [FREQ_W-1:0] freq_q, freq_eff;
  logic [REG_W-1:0]  view;

  strap_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst_rtc_i),
    .d_i ({pwr_good_i, strap_safe_i, strap_spkr_n_i}),
    .q_o (sync_q)
  );

  assign pg_s = sync_q[2];

  always_ff @(posedge clk) begin
    if (rst_rtc_i) pg_d <= 1'b0;
    else pg_d <= pg_s;
  end
  assign pg_rise = pg_s && !pg_d;

  assign hit = (addr_i[ADDR_W-1:2] == REG_ADDR[ADDR_W-1:2]);

  strap_cfg_fields #(.FW(FREQ_W)) u_fields (
    .clk        (clk),
    .rst_rtc_i  (rst_rtc_i),
    .rst_rsm_i  (rst_rsm_i),
    .rst_core_i (rst_core_i),
    .pg_rise_i  (pg_rise),
    .safe_s_i   (sync_q[1]),
    .spkr_n_s_i (sync_q[0]),
    .wr_hit_i   (wr_en_i && hit),
    .be_lo_i    (be_i[1:0]),
    .wdata_lo_i (wdata_i[15:0]),
    .swap_q     (swap_q),
    .bist_q     (bist_q),
    .freq_q     (freq_q),
    .safe_q     (safe_q),
    .norb_q     (norb_q)
  );

  assign freq_eff = safe_q ? FREQ_SAFE : freq_q;

  always_comb begin
    view = '0;
    view[BIT_SWAP] = swap_q;
    view[BIT_BIST] = bist_q;
    view[FREQ_LSB +: FREQ_W] = freq_eff;
    view[BIT_SAFE] = safe_q;
    view[BIT_NORB] = norb_q;
  end

  always_ff @(posedge clk) begin
    if (rst_core_i) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= hit ? view : '0;
  end

  always_ff @(posedge clk) begin
    if (rst_rsm_i) init_o <= 1'b0;
    else init_o <= bist_q && cpu_rst_i;
  end

  always_ff @(posedge clk) begin
    if (rst_rtc_i) begin
      fw_a16_o    <= 1'b0;
      top_swap_o  <= 1'b0;
      freq_mult_o <= '1;
      safe_mode_o <= 1'b0;
    end else begin
      fw_a16_o    <= fw_a16_i ^ (swap_q && fw_boot_sel_i);
      top_swap_o  <= swap_q;
      freq_mult_o <= freq_eff;
      safe_mode_o <= safe_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_core_i) no_reboot_o <= 1'b0;
    else no_reboot_o <= norb_q;
  end

  AST_INIT_OFF: assert property (@(posedge clk) disable iff (rst_rsm_i)
    !bist_q |=> !init_o); // R5
  AST_FREQ_FORCED: assert property (@(posedge clk) disable iff (rst_rtc_i)
    safe_q |=> (freq_mult_o == FREQ_SAFE)); // R6
  AST_FEATURE_NO_SWAP: assert property (@(posedge clk) disable iff (rst_rtc_i)
    !fw_boot_sel_i |=> (fw_a16_o == $past(fw_a16_i))); // R3
endmodule

// File: tb/strap_cfg_reg_test.sv
`timescale 1ns/1ps
module strap_cfg_reg_test;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_rtc, rst_rsm, rst_core;
  logic pwr_good, s_safe, s_spkr_n;
  logic rd_en, wr_en;
  logic [7:0] addr;
  logic [3:0] be;
  logic [31:0] wdata, rdata;
  logic cpu_rst, a16_in, boot_sel;
  logic a16_out, init_o, swap_o, safe_o, norb_o;
  logic [3:0] freq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  strap_cfg_reg uut (
    .clk(clk), .rst_rtc_i(rst_rtc), .rst_rsm_i(rst_rsm), .rst_core_i(rst_core),
    .pwr_good_i(pwr_good), .strap_safe_i(s_safe), .strap_spkr_n_i(s_spkr_n),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .be_i(be), .wdata_i(wdata),
    .rdata_o(rdata), .cpu_rst_i(cpu_rst), .fw_a16_i(a16_in), .fw_boot_sel_i(boot_sel),
    .fw_a16_o(a16_out), .init_o(init_o), .top_swap_o(swap_o), .freq_mult_o(freq_o),
    .safe_mode_o(safe_o), .no_reboot_o(norb_o)
  );

  // {be, wdata, expected read}
  localparam int NV = 6;
  localparam logic [67:0] VEC [NV] = '{
    {4'hF, 32'hFFFF_FFFF, 32'h0000_3F02},  // R2 reserved/read-only ignored
    {4'h1, 32'h0000_0000, 32'h0000_3F00},  // R8 clear allowed, strap high
    {4'h2, 32'h0000_A500, 32'h0000_2500},  // R9 only byte 1
    {4'h4, 32'h00FF_0000, 32'h0000_2500},  // R2 reserved byte
    {4'h1, 32'h0000_0006, 32'h0000_2502},  // R7 bit 2 not writable, R8 set
    {4'h2, 32'h0000_1300, 32'h0000_1302}   // R6 freq written while safe 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    addr = a; be = b; wdata = d; wr_en = 1;
    tick(1);
    wr_en = 0; be = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    tick(1);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic power_edge(input logic safe, input logic spkr_n);
    pwr_good = 0; tick(4);
    s_safe = safe; s_spkr_n = spkr_n; tick(4);
    pwr_good = 1; tick(6);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    rst_rtc = 1; rst_rsm = 1; rst_core = 1;
    pwr_good = 0; s_safe = 0; s_spkr_n = 1;
    rd_en = 0; wr_en = 0; addr = 8'hD4; be = 0; wdata = 0;
    cpu_rst = 0; a16_in = 0; boot_sel = 0;
    tick(3);
    rst_rtc = 0; rst_rsm = 0; rst_core = 0;
    tick(2);
    pwr_good = 1; tick(6);

    rd(8'hD4, r); check("R1 reset value", r, 32'h0000_0F00);
    check("R1 multiplier out", {28'h0, freq_o}, 32'hF);

    for (int i = 0; i < NV; i++) begin
      wr(8'hD4, VEC[i][67:64], VEC[i][63:32]);
      rd(8'hD4, r);
      check($sformatf("R9 vector %0d", i), r, VEC[i][31:0]);
    end

    // R3 swap
    boot_sel = 1; a16_in = 0; tick(2);
    check("R3 no swap when bit clear", {31'h0, a16_out}, 32'h0);
    wr(8'hD4, 4'h2, 32'h0000_3300);
    tick(2);
    check("R3 boot inverted", {31'h0, a16_out}, 32'h1);
    boot_sel = 0; tick(2);
    check("R3 feature not inverted", {31'h0, a16_out}, 32'h0);
    check("R3 swap out", {31'h0, swap_o}, 32'h1);

    // R5 init follows cpu reset
    cpu_rst = 1; tick(2);
    check("R5 init with bist", {31'h0, init_o}, 32'h1);
    rst_rsm = 1; tick(1); rst_rsm = 0; tick(2);
    check("R5 init after rsm reset", {31'h0, init_o}, 32'h0);
    rd(8'hD4, r); check("R5 bist cleared", r, 32'h0000_2302);

    // R4 core reset keeps swap and multiplier
    rst_core = 1; tick(1); rst_core = 0; tick(1);
    rd(8'hD4, r); check("R4 core reset keeps rtc bits", r, 32'h0000_2300);

    // R7/R6/R8 safe strap high, jumper fitted
    power_edge(1'b1, 1'b0);
    rd(8'hD4, r); check("R7 safe captured", r, 32'h0000_2F06);
    check("R6 multiplier forced", {28'h0, freq_o}, 32'hF);
    wr(8'hD4, 4'h3, 32'h0000_0500);
    rd(8'hD4, r); check("R8 clear blocked, R6 freq locked", r, 32'h0000_0F06);
    rst_core = 1; tick(1); rst_core = 0; tick(1);
    rd(8'hD4, r); check("R8 core reset clears", r, 32'h0000_0F04);

    // R10 rdata holds
    wr(8'hD4, 4'h2, 32'h0000_2000);
    tick(1);
    check("R10 rdata holds", rdata, 32'h0000_0F04);

    power_edge(1'b0, 1'b1);
    rd(8'hD4, r); check("R6 stored multiplier returns", r, 32'h0000_2300);
    check("R6 multiplier out", {28'h0, freq_o}, 32'h3);

    wr(8'hD0, 4'hF, 32'hFFFF_FFFF);
    rd(8'hD0, r); check("R9 other address reads zero", r, 32'h0);
    rd(8'hD4, r); check("R9 other address ignored", r, 32'h0000_2300);

    rst_rtc = 1; tick(1); rst_rtc = 0; tick(6);
    rd(8'hD4, r); check("R4 rtc reset clears", r, 32'h0000_0F00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule